// File: doc/BRIEF.md
# Memory Access Ordering Fence Unit

The fence unit sits between a processor's in-order stream of memory requests and a memory port that may finish requests in any order. Each request arrives tagged as a plain data access or as one of three ordering accesses: a full fence, an acquire or a release. The unit decides, cycle by cycle, whether the request at the head of the stream may go to memory. It keeps a bounded count of outstanding data accesses and a record of the single ordering access in flight. Memory reports each finished operation with a one-cycle pulse.

A mode input chooses between two ordering disciplines. In weak-ordering mode every ordering access behaves as a full fence. In release mode, an acquire may leave while older data is still in flight, but it holds back everything younger until it finishes. A release waits for all older accesses but lets younger data go past it. Requests pass straight through to the memory side in the cycle they are allowed. The gating depends only on registered state, so a completion pulse takes effect from the following cycle.

Top module: `fence_unit`

## Requirements
- R1: A request that is allowed appears on the issue port in the same cycle with its kind and tag unchanged, and `reqReady` equals `issueReady`. A request that is not allowed, or that meets `issueReady` low, is neither accepted nor issued. Kind encoding on `reqKind` and `issueKind`: 0 data, 1 full fence, 2 acquire, 3 release.
- R2: The outstanding-data count rises by one when a data request issues. It falls by one on a `doneData` pulse, and stays the same when both happen in one cycle. A `doneData` pulse while the count is zero is ignored.
- R3: While `MAX_OUT` data requests are outstanding, a data request is refused. It can be accepted from the cycle after a completion.
- R4: A full fence issues only while the outstanding-data count is zero.
- R5: After a full fence issues, no data request is accepted until the cycle after `doneSync`.
- R6: Ordering accesses leave one at a time, in program order. A new ordering access is not accepted while an earlier one awaits its `doneSync`.
- R7: In release mode an acquire may issue while data is outstanding. No later request of any kind is accepted until the cycle after its `doneSync`.
- R8: In release mode a release issues only when the outstanding-data count is zero. Later data requests may issue while the release is still outstanding.
- R9: In weak-ordering mode (`modeRelease` = 0), acquires and releases obey the full-fence rules of R4 and R5.
- R10: After reset nothing is outstanding, and a data request is accepted at once when `issueReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeRelease | input | 1 | 0 weak ordering, 1 release consistency |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqKind | input | 2 | Request kind (0 data, 1 fence, 2 acquire, 3 release) |
| reqTag | input | TAG_W | Request payload tag |
| issueValid | output | 1 | Request offered to memory |
| issueReady | input | 1 | Memory can take a request |
| issueKind | output | 2 | Kind of issued request |
| issueTag | output | TAG_W | Tag of issued request |
| doneData | input | 1 | One-cycle pulse: one data access finished |
| doneSync | input | 1 | One-cycle pulse: the ordering access finished |

## Verification
On every cycle, the embedded assertions check that the count stays within its bound and never moves below zero, that it holds steady when nothing changes it, that no data leaves while a blocking ordering access is in flight, that fences and releases leave only with the count at zero, and that only one ordering access is in flight at a time. What the assertions cannot show is that the right requests get through. That a release really lets younger data pass, that an acquire really overtakes older data, that weak-ordering mode turns acquires and releases into fences, and that the tags reach memory unchanged and in order are shown only by the bench's scripted sequences against its queue of expected issues.

// File: rtl/fence_pkg.sv
package fence_pkg;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_FULL = 2'd1,
    KIND_ACQ  = 2'd2,
    KIND_REL  = 2'd3
  } reqKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntUp;        // a data access leaves this cycle
    logic cntDown;      // a data access finished this cycle
    logic syncSet;      // an ordering access leaves this cycle
    logic syncBlockSet; // that ordering access holds back younger data
    logic syncClear;    // the ordering access finished this cycle
  } fenceStrobe_t;

endpackage

// File: rtl/fence_datapath.sv
module fence_datapath
  import fence_pkg::*;
#(
  parameter int MAX_OUT = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  fenceStrobe_t strobe,
  output logic         cntZero,
  output logic         cntFull,
  output logic         syncBusy,
  output logic         syncBlock
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] dataCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataCnt <= '0;
    end else if (strobe.cntUp && !strobe.cntDown) begin
      dataCnt <= dataCnt + 1'b1;
    end else if (strobe.cntDown && !strobe.cntUp) begin
      dataCnt <= dataCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncBusy  <= 1'b0;
      syncBlock <= 1'b0;
    end else if (strobe.syncSet) begin
      syncBusy  <= 1'b1;
      syncBlock <= strobe.syncBlockSet;
    end else if (strobe.syncClear) begin
      syncBusy  <= 1'b0;
      syncBlock <= 1'b0;
    end
  end

  assign cntZero = (dataCnt == '0);
  assign cntFull = (dataCnt == CNT_MAX);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataCnt <= CNT_MAX);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDown |-> dataCnt != '0);

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntUp == strobe.cntDown) |=> $stable(dataCnt));

  assert_block_implies_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncBlock |-> syncBusy);

endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl
  import fence_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeRelease,
  input  logic         reqValid,
  input  logic [1:0]   reqKind,
  input  logic         issueReady,
  input  logic         doneData,
  input  logic         doneSync,
  input  logic         cntZero,
  input  logic         cntFull,
  input  logic         syncBusy,
  input  logic         syncBlock,
  output logic         reqReady,
  output logic         issueValid,
  output fenceStrobe_t strobe
);

  reqKind_t rawKind;
  reqKind_t effKind;
  logic     allow;
  logic     fire;

  assign rawKind = reqKind_t'(reqKind);

  // Weak ordering folds acquire and release into a full fence
  always_comb begin
    if (!modeRelease && rawKind != KIND_DATA) effKind = KIND_FULL;
    else                                      effKind = rawKind;
  end

  always_comb begin
    unique case (effKind)
      KIND_DATA: allow = !syncBlock && !cntFull;
      KIND_ACQ:  allow = !syncBusy;
      KIND_FULL,
      KIND_REL:  allow = !syncBusy && cntZero;
      default:   allow = 1'b0;
    endcase
  end

  assign issueValid = reqValid && allow;
  assign reqReady   = issueReady && allow;
  assign fire       = reqValid && issueReady && allow;

  always_comb begin
    strobe              = '0;
    strobe.cntUp        = fire && (effKind == KIND_DATA);
    strobe.cntDown      = doneData && !cntZero;
    strobe.syncSet      = fire && (effKind != KIND_DATA);
    strobe.syncBlockSet = (effKind != KIND_REL);
    strobe.syncClear    = doneSync && syncBusy;
  end

  assert_data_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && issueReady && reqReady && rawKind == KIND_DATA) |-> !syncBlock);

  assert_fence_drained_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && (rawKind == KIND_FULL || rawKind == KIND_REL))
      |-> cntZero);

  assert_wo_acquire_drained_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !modeRelease && rawKind == KIND_ACQ) |-> cntZero);

  assert_single_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && rawKind != KIND_DATA) |-> !syncBusy);

  assert_sync_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && rawKind != KIND_DATA) |=> syncBusy);

endmodule

// File: rtl/fence_unit.sv
module fence_unit
  import fence_pkg::*;
#(
  parameter int MAX_OUT = 4,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeRelease,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqKind,
  input  logic [TAG_W-1:0] reqTag,
  output logic             issueValid,
  input  logic             issueReady,
  output logic [1:0]       issueKind,
  output logic [TAG_W-1:0] issueTag,
  input  logic             doneData,
  input  logic             doneSync
);

  fenceStrobe_t strobe;
  logic cntZero, cntFull, syncBusy, syncBlock;

  fence_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeRelease(modeRelease),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .issueReady (issueReady),
    .doneData   (doneData),
    .doneSync   (doneSync),
    .cntZero    (cntZero),
    .cntFull    (cntFull),
    .syncBusy   (syncBusy),
    .syncBlock  (syncBlock),
    .reqReady   (reqReady),
    .issueValid (issueValid),
    .strobe     (strobe)
  );

  fence_datapath #(.MAX_OUT(MAX_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntZero  (cntZero),
    .cntFull  (cntFull),
    .syncBusy (syncBusy),
    .syncBlock(syncBlock)
  );

  assign issueKind = reqKind;
  assign issueTag  = reqTag;

  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (issueValid && issueReady));

endmodule

// File: tb/fence_unit_bench.sv
module fence_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_OUT    = 4;
  localparam int TAG_W      = 8;
  localparam int WATCHDOG   = 5000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeRelease = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [1:0]       reqKind = 2'd0;
  logic [TAG_W-1:0] reqTag = '0;
  logic             issueValid;
  logic             issueReady = 1'b1;
  logic [1:0]       issueKind;
  logic [TAG_W-1:0] issueTag;
  logic             doneData = 1'b0;
  logic             doneSync = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [TAG_W+1:0] expQ[$];

  localparam logic [1:0] K_DATA = 2'd0, K_FULL = 2'd1, K_ACQ = 2'd2, K_REL = 2'd3;

  always #(CLK_PERIOD/2) clk = ~clk;

  fence_unit #(.MAX_OUT(MAX_OUT), .TAG_W(TAG_W)) u_fence_unit (
    .clk(clk), .rstN(rstN), .modeRelease(modeRelease),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind), .reqTag(reqTag),
    .issueValid(issueValid), .issueReady(issueReady),
    .issueKind(issueKind), .issueTag(issueTag),
    .doneData(doneData), .doneSync(doneSync)
  );

  task automatic finishRun();
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d expected issues never seen (expected 0)", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops the expected issue on every handshake at the memory side
  always @(negedge clk) begin
    if (rstN && issueValid && issueReady) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected issue kind %0d tag %0d (expected none)",
                 issueKind, issueTag);
      end else begin
        logic [TAG_W+1:0] e;
        e = expQ.pop_front();
        if ({issueKind, issueTag} !== e) begin
          fails++;
          $display("FAIL R1: issued kind %0d tag %0d, expected kind %0d tag %0d",
                   issueKind, issueTag, e[TAG_W+1:TAG_W], e[TAG_W-1:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected fewer)", WATCHDOG);
      finishRun();
    end
  end

  // One cycle of stimulus: a request (or none), completion pulses, expected ready
  task automatic cyc(input logic v, input logic [1:0] k, input int tag,
                     input logic expRdy, input logic dd, input logic ds,
                     input string req);
    reqValid = v;
    reqKind  = k;
    reqTag   = TAG_W'(tag);
    doneData = dd;
    doneSync = ds;
    if (v && expRdy && issueReady) expQ.push_back({k, TAG_W'(tag)});
    @(negedge clk);
    if (v) begin
      checks++;
      if (reqReady !== expRdy) begin
        fails++;
        $display("FAIL %s: tag %0d reqReady %b (expected %b)", req, tag, reqReady, expRdy);
      end
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
    doneData = 1'b0;
    doneSync = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state: data accepted at once
    cyc(1, K_DATA, 1, 1, 0, 0, "R10");
    // R3 fill to the bound
    cyc(1, K_DATA, 2, 1, 0, 0, "R3");
    cyc(1, K_DATA, 3, 1, 0, 0, "R3");
    cyc(1, K_DATA, 4, 1, 0, 0, "R3");
    cyc(1, K_DATA, 5, 0, 0, 0, "R3");
    cyc(1, K_DATA, 5, 0, 1, 0, "R3");   // completion frees a slot next cycle
    cyc(1, K_DATA, 5, 1, 0, 0, "R3");   // count back to 4
    // R2 issue and completion in one cycle
    cyc(1, K_DATA, 6, 0, 1, 0, "R3");   // count 3
    cyc(1, K_DATA, 6, 1, 1, 0, "R2");   // stays 3
    cyc(1, K_DATA, 7, 1, 0, 0, "R2");   // count 4
    cyc(1, K_DATA, 8, 0, 0, 0, "R2");   // full again proves the count

    // R4 full fence waits for drain
    cyc(1, K_FULL, 20, 0, 1, 0, "R4");
    cyc(1, K_FULL, 20, 0, 1, 0, "R4");
    cyc(1, K_FULL, 20, 0, 1, 0, "R4");
    cyc(1, K_FULL, 20, 0, 1, 0, "R4");  // count reaches 0 at this edge
    cyc(1, K_FULL, 20, 1, 0, 0, "R4");
    // R5 and R6 while the fence is in flight
    cyc(1, K_DATA, 9, 0, 0, 0, "R5");
    cyc(1, K_FULL, 21, 0, 0, 0, "R6");
    cyc(1, K_DATA, 9, 0, 0, 1, "R5");
    cyc(1, K_DATA, 9, 1, 0, 0, "R5");   // count 1

    // R2 completion at zero ignored
    cyc(0, K_DATA, 0, 0, 1, 0, "R2");   // count 0
    cyc(0, K_DATA, 0, 0, 1, 0, "R2");   // ignored
    cyc(0, K_DATA, 0, 0, 0, 1, "R6");   // stray sync done ignored
    cyc(1, K_DATA, 10, 1, 0, 0, "R2");  // count 1
    cyc(1, K_FULL, 22, 0, 0, 0, "R2");  // count not zero, no wrap
    cyc(1, K_FULL, 22, 0, 1, 0, "R4");
    cyc(1, K_FULL, 22, 1, 0, 0, "R4");
    cyc(0, K_DATA, 0, 0, 0, 1, "R5");

    // R9 weak ordering: acquire and release act as fences
    cyc(1, K_DATA, 11, 1, 0, 0, "R9");  // count 1
    cyc(1, K_ACQ, 30, 0, 0, 0, "R9");
    cyc(1, K_ACQ, 30, 0, 1, 0, "R9");
    cyc(1, K_ACQ, 30, 1, 0, 0, "R9");
    cyc(1, K_DATA, 12, 0, 0, 1, "R9");
    cyc(1, K_DATA, 12, 1, 0, 0, "R9");  // count 1
    cyc(1, K_REL, 31, 0, 1, 0, "R9");
    cyc(1, K_REL, 31, 1, 0, 0, "R9");
    cyc(1, K_DATA, 13, 0, 0, 1, "R9");  // release blocks data in this mode

    // R1 memory side not ready
    issueReady = 1'b0;
    cyc(1, K_DATA, 14, 0, 0, 0, "R1");
    issueReady = 1'b1;

    // Release consistency
    modeRelease = 1'b1;
    cyc(1, K_DATA, 15, 1, 0, 0, "R7");  // count 1
    cyc(1, K_ACQ, 40, 1, 0, 0, "R7");   // overtakes outstanding data
    cyc(1, K_DATA, 16, 0, 0, 0, "R7");
    cyc(1, K_REL, 41, 0, 0, 1, "R7");
    cyc(1, K_DATA, 16, 1, 0, 0, "R7");  // count 2
    cyc(1, K_REL, 41, 0, 1, 0, "R8");
    cyc(1, K_REL, 41, 0, 1, 0, "R8");
    cyc(1, K_REL, 41, 1, 0, 0, "R8");
    cyc(1, K_DATA, 17, 1, 0, 0, "R8");  // data passes the release
    cyc(1, K_ACQ, 42, 0, 0, 1, "R6");
    cyc(1, K_ACQ, 42, 1, 0, 0, "R7");   // data still outstanding
    cyc(0, K_DATA, 0, 0, 1, 1, "R7");
    cyc(0, K_DATA, 0, 0, 0, 0, "R7");

    finishRun();
  end

endmodule